// File: doc/BRIEF.md
# Receive Tail-Tag Timestamp Extractor

This block sits on the byte stream that a switch delivers to its host port. Every frame on that stream ends in a one-byte tail tag. When bit 7 of that tag is set, the frame is a precision-time frame, and the four bytes in front of the tag hold a partial ingress timestamp captured by the switch. The block holds back the trailing bytes of each frame until it has seen the tag. It then removes the trailer and forwards the frame body unchanged.

The partial timestamp is 32 bits wide. Its top 2 bits are the low bits of the seconds count and its low 30 bits are nanoseconds. The block extends this value to a full timestamp. It samples a free-running seconds reading from the local time-of-day clock, keeps that reading's upper bits and inserts the captured 2 bits as the low bits. If the result lies ahead of the reading, it steps the result back by one 4-second wrap. The extended timestamp appears with a valid pulse on the last beat of the stripped frame. A nanoseconds field that is out of range is reported as an error in place of a timestamp.

Top module: `rx_tailtag_ts`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid`, `ts_valid` and `ts_err` are low.
- R2: Frame bytes that come before the removed trailer leave on `out_data` unchanged and in arrival order. Idle cycles between the bytes of one frame do not change the content.
- R3: If bit 7 of the final byte is 1, the output frame omits the final 5 input bytes, and `out_last` marks the byte that was sixth from the end.
- R4: If bit 7 of the final byte is 0, only the final byte is omitted, and `out_last` marks the byte that was second from the end.
- R5: The four bytes just before the final byte form the partial timestamp, first byte as bits 31:24. Bits 29:0 are the nanoseconds and are reported on `ts_ns`.
- R6: `ts_sec` takes its upper bits from `ref_sec` as sampled in the cycle of the final byte and its low 2 bits from partial bits 31:30. When that value exceeds the sample, 4 is subtracted modulo 2^SEC_W.
- R7: `ts_valid` is high for exactly one cycle. It rises together with `out_last`, and only for a frame with bit 7 set whose nanoseconds are below 1,000,000,000.
- R8: For a frame with bit 7 set whose nanoseconds are 1,000,000,000 or more, `ts_err` pulses with `out_last` and `ts_valid` stays low.
- R9: A byte released by an input cycle appears two cycles later. On a frame whose bit 7 is clear, the four held bytes follow on the next four consecutive cycles. On any other cycle, `out_valid` is low.
- R10: Frames are at least 6 bytes long, and each frame's final byte is followed by at least 4 cycles with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the tail tag (last byte of frame) |
| ref_sec | input | SEC_W | Seconds reading of the local time-of-day clock |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte of stripped frame |
| out_last | output | 1 | Last byte of stripped frame |
| ts_valid | output | 1 | Extended timestamp valid pulse |
| ts_err | output | 1 | Partial nanoseconds out of range |
| ts_sec | output | SEC_W | Extended seconds |
| ts_ns | output | NS_BITS | Nanoseconds |

## Verification
The bench builds the block with its defaults: SEC_W of 32, 30 nanosecond bits and a 2-bit seconds fragment. With a 32-bit seconds reading the bench can drive references near zero, where stepping back by one wrap must go below zero and wrap to all ones. It can also drive references whose low two bits fall on either side of the captured fragment. With these widths, nanoseconds values on both sides of the one-second limit can be placed in the trailer directly.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef struct packed {
    logic  valid;
    byte_t data;
    logic  last;
  } beat_t;
endpackage

// File: rtl/tt_trailer_window.sv
module tt_trailer_window
  import ttx_pkg::*;
#(
  parameter int NS_BITS = 30,
  parameter int SEC_LOW = 2,
  parameter int SEC_W   = 32,
  parameter int TAG_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  byte_t              in_data,
  input  logic               in_last,
  input  logic [SEC_W-1:0]   ref_sec,
  output beat_t              beat,
  output logic               frame_done,
  output logic               frame_ptp,
  output logic [NS_BITS+SEC_LOW-1:0] ts_raw,
  output logic [SEC_W-1:0]   ref_snap
);
  localparam int RAW_W    = NS_BITS + SEC_LOW;
  localparam int TS_BYTES = RAW_W / BYTE_W;
  localparam int HOLD     = TS_BYTES + 1;
  localparam int CW       = $clog2(HOLD + 1);
  localparam int DW       = $clog2(TS_BYTES + 1);

  byte_t            win [HOLD];
  logic [CW-1:0]    fill;
  logic [DW-1:0]    drain;
  logic [RAW_W-1:0] raw_now;
  logic             full;
  logic             take_tag;
  logic             take_byte;

  assign full      = (fill == CW'(HOLD));
  assign take_tag  = (drain == '0) && in_valid && in_last;
  assign take_byte = (drain == '0) && in_valid && !in_last;

  // partial timestamp: entries 1..TS_BYTES of the window, first is MSB
  always_comb begin
    raw_now = '0;
    for (int i = 0; i < TS_BYTES; i++)
      raw_now[RAW_W-1-BYTE_W*i -: BYTE_W] = win[i+1];
  end

  // control path
  always_ff @(posedge clk) begin
    if (rst) begin
      fill        <= '0;
      drain       <= '0;
      beat.valid  <= 1'b0;
      beat.last   <= 1'b0;
      frame_done  <= 1'b0;
      frame_ptp   <= 1'b0;
    end else begin
      beat.valid <= 1'b0;
      beat.last  <= 1'b0;
      frame_done <= 1'b0;
      if (drain != '0) begin
        beat.valid <= 1'b1;
        beat.last  <= (drain == DW'(1));
        frame_done <= (drain == DW'(1));
        drain      <= drain - DW'(1);
      end else if (take_tag) begin
        beat.valid <= full;
        frame_ptp  <= in_data[TAG_BIT];
        fill       <= '0;
        if (in_data[TAG_BIT]) begin
          beat.last  <= 1'b1;
          frame_done <= 1'b1;
        end else begin
          drain <= DW'(TS_BYTES);
        end
      end else if (take_byte) begin
        beat.valid <= full;
        if (!full) fill <= fill + CW'(1);
      end
    end
  end

  // data path (no reset)
  always_ff @(posedge clk) begin
    if (drain != '0) begin
      beat.data <= win[1];
      for (int i = 1; i < HOLD - 1; i++) win[i] <= win[i+1];
    end else if (take_tag) begin
      beat.data <= win[0];
      ts_raw    <= raw_now;
      ref_snap  <= ref_sec;
    end else if (take_byte) begin
      beat.data <= win[0];
      for (int i = 0; i < HOLD - 1; i++) win[i] <= win[i+1];
      win[HOLD-1] <= in_data;
    end
  end
endmodule

// File: rtl/tt_ts_rebuild.sv
module tt_ts_rebuild #(
  parameter int NS_BITS = 30,
  parameter int SEC_LOW = 2,
  parameter int SEC_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_done,
  input  logic                       frame_ptp,
  input  logic [NS_BITS+SEC_LOW-1:0] ts_raw,
  input  logic [SEC_W-1:0]           ref_snap,
  output logic                       ts_valid,
  output logic                       ts_err,
  output logic [SEC_W-1:0]           ts_sec,
  output logic [NS_BITS-1:0]         ts_ns
);
  localparam logic [NS_BITS-1:0] NS_LIMIT = NS_BITS'(1000000000);
  localparam logic [SEC_W-1:0]   WRAP     = SEC_W'(1) << SEC_LOW;

  logic [NS_BITS-1:0] ns_part;
  logic [SEC_W-1:0]   joined;
  logic [SEC_W-1:0]   sec_fix;
  logic               ns_ok;

  assign ns_part = ts_raw[NS_BITS-1:0];
  assign ns_ok   = (ns_part < NS_LIMIT);

  generate
    if (SEC_W > SEC_LOW) begin : g_join
      assign joined = {ref_snap[SEC_W-1:SEC_LOW], ts_raw[NS_BITS+SEC_LOW-1:NS_BITS]};
    end else begin : g_narrow
      assign joined = ts_raw[NS_BITS +: SEC_W];
    end
  endgenerate

  assign sec_fix = (joined > ref_snap) ? (joined - WRAP) : joined;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_valid <= 1'b0;
      ts_err   <= 1'b0;
    end else begin
      ts_valid <= frame_done && frame_ptp && ns_ok;
      ts_err   <= frame_done && frame_ptp && !ns_ok;
    end
  end

  always_ff @(posedge clk) begin
    ts_sec <= sec_fix;
    ts_ns  <= ns_part;
  end
endmodule

// File: rtl/rx_tailtag_ts.sv
module rx_tailtag_ts
  import ttx_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int NS_BITS = 30,
  parameter int SEC_LOW = 2,
  parameter int TAG_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic [SEC_W-1:0]   ref_sec,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_last,
  output logic               ts_valid,
  output logic               ts_err,
  output logic [SEC_W-1:0]   ts_sec,
  output logic [NS_BITS-1:0] ts_ns
);
  localparam int RAW_W = NS_BITS + SEC_LOW;

  beat_t            beat;
  logic             frame_done;
  logic             frame_ptp;
  logic [RAW_W-1:0] ts_raw;
  logic [SEC_W-1:0] ref_snap;

  tt_trailer_window #(
    .NS_BITS(NS_BITS), .SEC_LOW(SEC_LOW), .SEC_W(SEC_W), .TAG_BIT(TAG_BIT)
  ) u_window (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .ref_sec(ref_sec),
    .beat(beat), .frame_done(frame_done), .frame_ptp(frame_ptp),
    .ts_raw(ts_raw), .ref_snap(ref_snap)
  );

  tt_ts_rebuild #(
    .NS_BITS(NS_BITS), .SEC_LOW(SEC_LOW), .SEC_W(SEC_W)
  ) u_rebuild (
    .clk(clk), .rst(rst),
    .frame_done(frame_done), .frame_ptp(frame_ptp),
    .ts_raw(ts_raw), .ref_snap(ref_snap),
    .ts_valid(ts_valid), .ts_err(ts_err), .ts_sec(ts_sec), .ts_ns(ts_ns)
  );

  // output stage, aligned with the rebuilt timestamp register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= beat.valid;
      out_last  <= beat.valid && beat.last;
    end
  end

  always_ff @(posedge clk) out_data <= beat.data;
endmodule

// File: rtl/rx_tailtag_ts_chk.sv
module rx_tailtag_ts_chk #(
  parameter int SEC_W   = 32,
  parameter int NS_BITS = 30
) (
  input logic               clk,
  input logic               rst,
  input logic [SEC_W-1:0]   ref_sec,
  input logic               out_valid,
  input logic               out_last,
  input logic               ts_valid,
  input logic               ts_err,
  input logic [SEC_W-1:0]   ts_sec,
  input logic [NS_BITS-1:0] ts_ns
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !ts_valid && !ts_err));

  a_r7_ts_on_last: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> (out_valid && out_last));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ts_valid |=> !ts_valid);

  a_r8_err_excludes_ts: assert property (@(posedge clk) disable iff (rst)
    ts_err |-> (out_valid && out_last && !ts_valid));

  a_r5_ns_in_range: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> (ts_ns < NS_BITS'(1000000000)));

  a_r6_sec_window: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> (($past(ref_sec, 2) - ts_sec) < SEC_W'(4)));
endmodule

bind rx_tailtag_ts rx_tailtag_ts_chk #(.SEC_W(SEC_W), .NS_BITS(NS_BITS)) u_chk (
  .clk(clk), .rst(rst), .ref_sec(ref_sec),
  .out_valid(out_valid), .out_last(out_last),
  .ts_valid(ts_valid), .ts_err(ts_err), .ts_sec(ts_sec), .ts_ns(ts_ns)
);

// File: tb/test_rx_tailtag_ts.sv
module test_rx_tailtag_ts;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic [SEC_W-1:0] ref_sec = '0;
  logic out_valid, out_last, ts_valid, ts_err;
  logic [7:0] out_data;
  logic [SEC_W-1:0] ts_sec;
  logic [29:0] ts_ns;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tailtag_ts i_rx_tailtag_ts (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .ref_sec(ref_sec), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .ts_valid(ts_valid),
    .ts_err(ts_err), .ts_sec(ts_sec), .ts_ns(ts_ns)
  );

  typedef struct { bit v; bit [7:0] d; bit l; longint r; } stim_t;
  typedef struct { bit d_ok; bit [7:0] d; bit l; bit tv; bit te; longint sec; longint ns; } exp_t;

  stim_t stim[$];
  exp_t  expq[int];
  bit [7:0] hold[$];
  int edge_n = 0;
  int checks = 0, failures = 0;
  int last_sched = 0;

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, edge_n, act, exp);
    end
  endtask

  task automatic add_frame(int plen, bit ptp, bit [7:0] tag_low, bit [1:0] sfrag,
                           bit [29:0] ns, longint refv, bit gaps);
    bit [31:0] raw = {sfrag, ns};
    stim_t s;
    for (int i = 0; i < plen; i++) begin
      s = '{1, 8'(i * 7 + plen), 0, refv};
      stim.push_back(s);
      if (gaps && (i % 2 == 0)) stim.push_back('{0, 0, 0, refv});
    end
    for (int i = 0; i < 4; i++) stim.push_back('{1, raw[31-8*i -: 8], 0, refv});
    stim.push_back('{1, {ptp, tag_low[6:0]}, 1, refv});
    for (int i = 0; i < 5; i++) stim.push_back('{0, 0, 0, refv});
  endtask

  // behavioural model: last five bytes of each frame are withheld
  task automatic model(stim_t s);
    int vis = edge_n + 2;
    exp_t e;
    longint base, nsv;
    bit [31:0] raw;
    if (!s.v) return;
    if (!s.l) begin
      hold.push_back(s.d);
      if (hold.size() > 5) begin
        e = '{1, hold.pop_front(), 0, 0, 0, 0, 0};
        expq[vis] = e;
      end
      return;
    end
    raw = {hold[1], hold[2], hold[3], hold[4]};
    if (s.d[7]) begin
      nsv = raw[29:0];
      base = (s.r & ~longint'(3)) | longint'(raw[31:30]);
      if (base > s.r) base = base - 4;
      base = base & 64'hFFFF_FFFF;
      e = '{1, hold[0], 1, nsv < 1000000000, nsv >= 1000000000, base, nsv};
      expq[vis] = e;
      last_sched = vis;
    end else begin
      expq[vis] = '{1, hold[0], 0, 0, 0, 0, 0};
      for (int k = 1; k <= 4; k++) expq[vis + k] = '{1, hold[k], k == 4, 0, 0, 0, 0};
      last_sched = vis + 4;
    end
    hold.delete();
  endtask

  task automatic compare();
    exp_t e;
    if (expq.exists(edge_n)) begin
      e = expq[edge_n];
      chk(out_valid == 1'b1, "R9 out_valid", out_valid, 1);
      chk(out_data == e.d, "R2,R10 out_data", out_data, e.d);
      chk(out_last == e.l, "R3|R4 out_last", out_last, e.l);
      chk(ts_valid == e.tv, "R7 ts_valid", ts_valid, e.tv);
      chk(ts_err == e.te, "R8 ts_err", ts_err, e.te);
      if (e.tv) begin
        chk(ts_sec == SEC_W'(e.sec), "R6 ts_sec", ts_sec, e.sec);
        chk(ts_ns == 30'(e.ns), "R5 ts_ns", ts_ns, e.ns);
      end
      expq.delete(edge_n);
    end else begin
      chk(!out_valid && !ts_valid && !ts_err, "R9 idle", {out_valid, ts_valid, ts_err}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    stim_t s;
    add_frame(5, 0, 7'h00, 0, 0, 100, 0);                 // R4 plain frame
    add_frame(7, 1, 7'h01, 2'd2, 30'd123456789, 1000, 0); // R3 R5 R6 step back
    add_frame(3, 1, 7'h00, 2'd0, 30'd5, 1003, 0);         // R6 no step
    add_frame(4, 1, 7'h02, 2'd1, 30'd1000000000, 50, 0);  // R8 at limit
    add_frame(2, 1, 7'h00, 2'd3, 30'd999999999, 1, 0);    // R6 wrap below zero
    add_frame(1, 0, 7'h7F, 2'd3, 30'h3FFFFFFF, 9, 1);     // R4 R10 min length, gaps
    add_frame(1, 1, 7'h00, 2'd1, 30'd42, 6, 1);           // R3 R10 min ptp, gaps
    add_frame(3, 1, 7'h00, 2'd3, 30'h3FFFFFFF, 7, 0);     // R8 max ns
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !ts_valid && !ts_err, "R1 reset", {out_valid, ts_valid, ts_err}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !ts_valid && !ts_err, "R1 after reset", {out_valid, ts_valid, ts_err}, 0);
    while (stim.size() > 0 || edge_n <= last_sched + 3) begin
      @(negedge clk);
      compare();
      if (stim.size() > 0) begin
        s = stim.pop_front();
        in_valid = s.v; in_data = s.d; in_last = s.l; ref_sec = SEC_W'(s.r);
        model(s);
      end else begin
        in_valid = 0; in_last = 0;
      end
    end
    chk(expq.size() == 0, "R9 all beats seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule